// File: doc/BRIEF.md
# Programmable Event Counter Bank

This block holds a small bank of general-purpose event counters for performance sampling. Each cycle it receives a set of event lanes. Every lane carries a valid pulse, an 8-bit event code and an 8-bit qualifier. It also receives a privilege input that says whether the current work is user-level or kernel-level. Every counter has its own selector register. The selector picks which event code to count, which qualifier bits must match, an optional per-cycle threshold, the privilege levels to count in, whether overflow raises the interrupt, and a local enable.

Software reaches all state over a simple register bus. Writes take effect on the clock edge and reads are combinational. To sample, software arms a counter with the negation of the desired period. The counter then counts upward and sets its sticky overflow flag when it carries out past the all-ones value. A level interrupt collects every flagged counter whose interrupt bit is set. A global enable register can freeze the whole bank in one write and later restore the exact set that was running.

Top module: `evt_counter_bank`

## Requirements
- R1: After a synchronous active-low reset, every selector, counter, the global enable and the overflow status read as zero, and `irq` is low.
- R2: Register map (6-bit address): selector of counter i at 0x00+i, counter i at 0x10+i, global enable at 0x20, overflow status at 0x21 (read only), overflow clear at 0x22 (write only, reads 0), arm of counter i at 0x30+i (write only, reads 0). Selector fields: event code [7:0], unit mask [15:8], count-in-user [16], count-in-kernel [17], interrupt-on-overflow [20], local enable [22], threshold [31:24]. Unimplemented selector bits read 0. A counter write keeps only the low CTR_W bits.
- R3: A lane qualifies for a counter when its valid bit is set, its code equals the selector code, and either the unit mask is zero or the lane qualifier ANDed with the unit mask is nonzero. With a zero threshold, the counter adds the number of qualifying lanes in that cycle.
- R4: With a nonzero threshold, the counter adds exactly 1 in cycles where the number of qualifying lanes is at least the threshold, and 0 otherwise.
- R5: A counter advances only when its local enable, its global enable bit, and the privilege filter all allow it. With `priv_user`=1 the user bit is consulted, and with 0 the kernel bit.
- R6: Writing 0 to the global enable freezes every counter. Writing the saved value back resumes exactly the previously running set.
- R7: A carry out of bit CTR_W-1 sets the counter's status bit. The counter keeps the wrapped low bits and continues counting. The status bit stays set through further overflows until it is cleared.
- R8: Writing to the clear register clears each status bit whose write-data bit is 1, and bits written 0 are unaffected. An overflow in the same cycle as its clear leaves the status bit set.
- R9: `irq` is high exactly when some status bit is set and that counter's interrupt-on-overflow bit is set.
- R10: Writing a period P to an arm address loads the counter with the two's complement of P, truncated to CTR_W bits. When CLAMP32 is 1, a P that is zero, negative as a 64-bit value, or above 0x7FFFFFFF is replaced with 0x7FFFFFFF.
- R11: A counter or arm write in the same cycle as qualifying events loads the written value and discards that cycle's increment.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Combinational read data for `reg_addr` |
| evt_vld | input | LANES | Per-lane event valid pulse |
| evt_code | input | LANES*8 | Per-lane event code, lane l in bits [8l+7:8l] |
| evt_qual | input | LANES*8 | Per-lane unit qualifier, same packing |
| priv_user | input | 1 | 1 = user level, 0 = kernel level |
| irq | output | 1 | Level overflow interrupt |

## Verification
The counting path is driven with random lane valids, codes drawn from a small set so that matches are frequent, and random qualifier bytes, so that all four counters see zero, one and several hits per cycle. Counters are configured with mixed unit masks and thresholds, which separates a summing counter from a threshold counter on the same stream. Random privilege toggles against mixed user and kernel flags show whether the filter is applied per counter. Short arm periods force frequent wraps, and these are mixed with clears, global enable writes and counter writes that land in the same cycle as events, which exposes errors in the write-versus-count and clear-versus-overflow priorities. Directed cases pin the arm clamp limits, the selector readback mask and a freeze-then-resume of the global enable.

// File: rtl/ecb_pkg.sv
// ecb_pkg: shared constants and helpers for the event counter bank.
// Assumes a 64-bit register bus and a 6-bit address space.
package ecb_pkg;
    localparam int BUS_W  = 64;
    localparam int ADDR_W = 6;
    localparam int CODE_W = 8;

    localparam logic [ADDR_W-1:0] A_SEL  = 6'h00;
    localparam logic [ADDR_W-1:0] A_CNT  = 6'h10;
    localparam logic [ADDR_W-1:0] A_GEN  = 6'h20;
    localparam logic [ADDR_W-1:0] A_STAT = 6'h21;
    localparam logic [ADDR_W-1:0] A_CLR  = 6'h22;
    localparam logic [ADDR_W-1:0] A_ARM  = 6'h30;

    localparam int B_USR = 16;
    localparam int B_KRN = 17;
    localparam int B_INT = 20;
    localparam int B_EN  = 22;
    localparam logic [31:0] SEL_MASK = 32'hFF53_FFFF;

    // Two's complement of a sampling period, with optional 31-bit clamp (R10)
    function automatic logic [BUS_W-1:0] arm_value(input logic [BUS_W-1:0] period,
                                                    input logic clamp32);
        logic [BUS_W-1:0] p;
        p = period;
        if (clamp32 && (p == '0 || p[BUS_W-1] || p > 64'h0000_0000_7FFF_FFFF))
            p = 64'h0000_0000_7FFF_FFFF;
        return ~p + 64'd1;
    endfunction
endpackage

// File: rtl/ecb_qualify.sv
// ecb_qualify: counts the event lanes that match one counter's selector and
// turns that count into the per-cycle increment (sum or threshold mode).
// Assumes INC_W can hold LANES.
module ecb_qualify #(
    parameter int LANES = 4,
    parameter int INC_W = 3
) (
    input  logic [LANES-1:0]   vld,
    input  logic [LANES*8-1:0] code,
    input  logic [LANES*8-1:0] qual,
    input  logic [7:0]         sel_code,
    input  logic [7:0]         sel_umask,
    input  logic [7:0]         sel_thresh,
    output logic [INC_W-1:0]   inc
);
    logic [INC_W-1:0] hits;

    // Population count of lanes matching code and unit mask
    always_comb begin
        hits = '0;
        for (int l = 0; l < LANES; l++) begin
            if (vld[l] && code[l*8 +: 8] == sel_code &&
                (sel_umask == 8'd0 || (qual[l*8 +: 8] & sel_umask) != 8'd0))
                hits = hits + 1'b1;
        end
    end

    // Sum mode when threshold is zero, else one per cycle meeting threshold
    always_comb begin
        if (sel_thresh == 8'd0)
            inc = hits;
        else if (32'(hits) >= 32'(sel_thresh))
            inc = INC_W'(1);
        else
            inc = '0;
    end
endmodule

// File: rtl/ecb_counter_slice.sv
// ecb_counter_slice: one counter register with load priority over counting
// and a carry-out pulse on wrap. Assumes INC_W <= CTR_W.
module ecb_counter_slice #(
    parameter int CTR_W = 48,
    parameter int INC_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [INC_W-1:0] inc,
    input  logic             ld,
    input  logic [CTR_W-1:0] ld_val,
    output logic [CTR_W-1:0] cnt,
    output logic             wrap
);
    logic [CTR_W:0] sum;

    // Widened add so the carry out marks an overflow
    always_comb begin
        sum  = {1'b0, cnt} + (CTR_W+1)'(inc);
        wrap = run && !ld && sum[CTR_W];
    end

    // Counter register: load wins over count
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (ld)
            cnt <= ld_val;
        else if (run)
            cnt <= sum[CTR_W-1:0];
    end
endmodule

// File: rtl/evt_counter_bank.sv
// evt_counter_bank: NUM_CTR programmable event counters with selectors,
// global enable, sticky overflow status, clear and level interrupt.
// Assumes NUM_CTR <= 16 and CTR_W <= 64; reads are combinational.
module evt_counter_bank
    import ecb_pkg::*;
#(
    parameter int NUM_CTR = 4,
    parameter int CTR_W   = 48,
    parameter int LANES   = 4,
    parameter bit CLAMP32 = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [5:0]         reg_addr,
    input  logic [63:0]        reg_wdata,
    output logic [63:0]        reg_rdata,
    input  logic [LANES-1:0]   evt_vld,
    input  logic [LANES*8-1:0] evt_code,
    input  logic [LANES*8-1:0] evt_qual,
    input  logic               priv_user,
    output logic               irq
);
    localparam int INC_W = $clog2(LANES + 1);

    logic [31:0]          sel_q [NUM_CTR];
    logic [CTR_W-1:0]     cnt_q [NUM_CTR];
    logic [NUM_CTR-1:0]   glb_en;
    logic [NUM_CTR-1:0]   ovf_stat;
    logic [NUM_CTR-1:0]   wrap_vec;
    logic [NUM_CTR-1:0]   int_vec;
    logic [NUM_CTR-1:0]   clr_bits;
    logic [NUM_CTR*CTR_W-1:0] cnt_flat;
    logic [BUS_W-1:0]     arm_full;

    // Armed load value shared by all counters
    always_comb arm_full = arm_value(reg_wdata, CLAMP32);

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
        logic [INC_W-1:0] inc;
        logic             run;
        logic             ld;
        logic [CTR_W-1:0] ld_val;

        // Selector register, unimplemented bits dropped
        always_ff @(posedge clk) begin
            if (!rst_n)
                sel_q[i] <= '0;
            else if (reg_wr && reg_addr == A_SEL + 6'(i))
                sel_q[i] <= reg_wdata[31:0] & SEL_MASK;
        end

        // Gate: local enable, global bit and privilege filter
        always_comb begin
            run = sel_q[i][B_EN] && glb_en[i] &&
                  (priv_user ? sel_q[i][B_USR] : sel_q[i][B_KRN]);
            ld  = reg_wr && (reg_addr == A_CNT + 6'(i) || reg_addr == A_ARM + 6'(i));
            ld_val = (reg_addr == A_ARM + 6'(i)) ? arm_full[CTR_W-1:0]
                                                 : reg_wdata[CTR_W-1:0];
            int_vec[i] = sel_q[i][B_INT];
            cnt_flat[i*CTR_W +: CTR_W] = cnt_q[i];
        end

        ecb_qualify #(.LANES(LANES), .INC_W(INC_W)) i_qual (
            .vld       (evt_vld),
            .code      (evt_code),
            .qual      (evt_qual),
            .sel_code  (sel_q[i][7:0]),
            .sel_umask (sel_q[i][15:8]),
            .sel_thresh(sel_q[i][31:24]),
            .inc       (inc)
        );

        ecb_counter_slice #(.CTR_W(CTR_W), .INC_W(INC_W)) i_slice (
            .clk   (clk),
            .rst_n (rst_n),
            .run   (run),
            .inc   (inc),
            .ld    (ld),
            .ld_val(ld_val),
            .cnt   (cnt_q[i]),
            .wrap  (wrap_vec[i])
        );
    end

    // Clear mask from a write to the clear register
    always_comb clr_bits = (reg_wr && reg_addr == A_CLR) ? reg_wdata[NUM_CTR-1:0] : '0;

    // Global enable and sticky overflow status; new overflow beats clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            glb_en   <= '0;
            ovf_stat <= '0;
        end else begin
            if (reg_wr && reg_addr == A_GEN)
                glb_en <= reg_wdata[NUM_CTR-1:0];
            ovf_stat <= (ovf_stat & ~clr_bits) | wrap_vec;
        end
    end

    // Level interrupt from enabled status bits
    always_comb irq = |(ovf_stat & int_vec);

    // Read mux
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_GEN)
            reg_rdata = BUS_W'(glb_en);
        else if (reg_addr == A_STAT)
            reg_rdata = BUS_W'(ovf_stat);
        for (int i = 0; i < NUM_CTR; i++) begin
            if (reg_addr == A_SEL + 6'(i))
                reg_rdata = BUS_W'(sel_q[i]);
            else if (reg_addr == A_CNT + 6'(i))
                reg_rdata = BUS_W'(cnt_q[i]);
        end
    end
endmodule

// File: rtl/ecb_checker.sv
// ecb_checker: temporal properties of evt_counter_bank, bound to every instance.
module ecb_checker #(
    parameter int NUM_CTR = 4,
    parameter int CTR_W   = 48
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     reg_wr,
    input logic [5:0]               reg_addr,
    input logic [63:0]              reg_wdata,
    input logic [NUM_CTR-1:0]       status,
    input logic [NUM_CTR-1:0]       gctl,
    input logic [NUM_CTR*CTR_W-1:0] cnt_flat,
    input logic                     irq
);
    // R1: leaving reset, no overflow is pending and the interrupt is quiet
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (status == '0 && !irq));

    // R9: the interrupt is never raised without a pending overflow
    p_irq_has_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status != '0));

    // R6: with the whole bank disabled and no counter load, counts hold
    p_frozen_bank_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (gctl == '0 && !(reg_wr && reg_addr[4] == 1'b1 && reg_addr[5] == reg_addr[5]
                         && (reg_addr[5:4] == 2'b01 || reg_addr[5:4] == 2'b11)))
        |=> $stable(cnt_flat));

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_bit
        // R7: a pending overflow persists unless its clear bit is written
        p_sticky_ovf_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (status[i] && !(reg_wr && reg_addr == 6'h22 && reg_wdata[i])) |=> status[i]);
    end
endmodule

bind evt_counter_bank ecb_checker #(.NUM_CTR(NUM_CTR), .CTR_W(CTR_W)) i_ecb_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .status   (ovf_stat),
    .gctl     (glb_en),
    .cnt_flat (cnt_flat),
    .irq      (irq)
);

// File: tb/test_evt_counter_bank.sv
// test_evt_counter_bank: directed corner cases plus seeded random traffic,
// checked against a requirement-level model kept in the bench.
module test_evt_counter_bank;
    localparam int CLK_P = 20;
    localparam int NC    = 4;
    localparam longint unsigned MASK = 64'h0000_FFFF_FFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic [3:0]  evt_vld = '0;
    logic [31:0] evt_code = '0;
    logic [31:0] evt_qual = '0;
    logic        priv_user = 1'b0;
    logic        irq;

    int ntest = 0;
    int nfail = 0;
    bit done  = 1'b0;

    logic [31:0]     m_sel [NC];
    longint unsigned m_cnt [NC];
    logic [3:0]      m_gen;
    logic [3:0]      m_stat;

    evt_counter_bank i_evt_counter_bank (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_vld(evt_vld),
        .evt_code(evt_code), .evt_qual(evt_qual), .priv_user(priv_user), .irq(irq)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        ntest++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic longint unsigned arm_exp(input logic [63:0] p);
        logic [63:0] q = p;
        if (q == 0 || q[63] || q > 64'h7FFF_FFFF) q = 64'h7FFF_FFFF;
        return (~q + 64'd1) & MASK;
    endfunction

    function automatic int lane_hits(input int c, input logic [3:0] v,
                                     input logic [31:0] cd, input logic [31:0] ql);
        int h = 0;
        for (int l = 0; l < 4; l++)
            if (v[l] && cd[l*8 +: 8] == m_sel[c][7:0] &&
                (m_sel[c][15:8] == 0 || (ql[l*8 +: 8] & m_sel[c][15:8]) != 0))
                h++;
        return h;
    endfunction

    task automatic read_reg(input logic [5:0] a, output logic [63:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic verify(input string tag);
        logic [63:0] d;
        logic        ie;
        for (int c = 0; c < NC; c++) begin
            read_reg(6'h10 + 6'(c), d);
            chk({tag, " counter"}, d, m_cnt[c]);
        end
        read_reg(6'h21, d);
        chk({tag, " status"}, d, 64'(m_stat));
        ie = 1'b0;
        for (int c = 0; c < NC; c++) ie |= m_stat[c] & m_sel[c][20];
        chk({tag, " R9 irq"}, 64'(irq), 64'(ie));
    endtask

    // One clock: drive inputs, advance model, then check after the edge
    task automatic step(input bit wr, input logic [5:0] a, input logic [63:0] d,
                        input logic [3:0] v, input logic [31:0] cd, input logic [31:0] ql,
                        input bit pu, input string tag);
        longint unsigned nc [NC];
        logic [3:0] ovf = '0;
        reg_wr = wr; reg_addr = a; reg_wdata = d;
        evt_vld = v; evt_code = cd; evt_qual = ql; priv_user = pu;
        for (int c = 0; c < NC; c++) begin
            int  h  = lane_hits(c, v, cd, ql);
            int  th = int'(m_sel[c][31:24]);
            longint unsigned inc = (th == 0) ? longint'(h) : ((h >= th) ? 1 : 0);
            bit  run = m_sel[c][22] && m_gen[c] && (pu ? m_sel[c][16] : m_sel[c][17]);
            if (wr && a == 6'h10 + 6'(c))      nc[c] = d & MASK;
            else if (wr && a == 6'h30 + 6'(c)) nc[c] = arm_exp(d);
            else if (run) begin
                longint unsigned s = m_cnt[c] + inc;
                if (s > MASK) ovf[c] = 1'b1;
                nc[c] = s & MASK;
            end else nc[c] = m_cnt[c];
        end
        m_stat = (m_stat & ~((wr && a == 6'h22) ? d[3:0] : 4'h0)) | ovf;
        for (int c = 0; c < NC; c++) begin
            if (wr && a == 6'h00 + 6'(c)) m_sel[c] = d[31:0] & 32'hFF53_FFFF;
            m_cnt[c] = nc[c];
        end
        if (wr && a == 6'h20) m_gen = d[3:0];
        @(posedge clk);
        #1;
        reg_wr = 1'b0; evt_vld = '0;
        verify(tag);
    endtask

    task automatic wr_step(input logic [5:0] a, input logic [63:0] d, input string tag);
        step(1'b1, a, d, 4'h0, 32'h0, 32'h0, 1'b0, tag);
    endtask

    // Selector image: code, umask, threshold, user, kernel, int, enable
    function automatic logic [63:0] sel_img(input logic [7:0] cd, input logic [7:0] um,
                                            input logic [7:0] th, input bit u, input bit k,
                                            input bit it, input bit en);
        return 64'({th, 1'b0, en, 1'b0, it, 2'b00, k, u, um, cd});
    endfunction

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", ntest, nfail);
            $finish;
        end
    end

    initial begin
        logic [63:0] d;
        void'($urandom(32'd20240611));
        for (int c = 0; c < NC; c++) begin m_sel[c] = '0; m_cnt[c] = 0; end
        m_gen = '0; m_stat = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        for (int c = 0; c < NC; c++) begin
            read_reg(6'h00 + 6'(c), d); chk("R1 selector", d, 64'h0);
        end
        read_reg(6'h20, d); chk("R1 global enable", d, 64'h0);
        verify("R1");

        // R2: selector mask and counter width truncation
        wr_step(6'h00, 64'hFFFF_FFFF_FFFF_FFFF, "R2");
        read_reg(6'h00, d); chk("R2 selector readback", d, 64'hFF53_FFFF);
        wr_step(6'h10, 64'hFFFF_FFFF_FFFF_FFFF, "R2");
        read_reg(6'h10, d); chk("R2 counter truncation", d, 64'h0000_FFFF_FFFF_FFFF);
        read_reg(6'h22, d); chk("R2 clear reads zero", d, 64'h0);

        // R10: arm values and clamp limits
        wr_step(6'h31, 64'd5, "R10");
        read_reg(6'h11, d); chk("R10 arm 5", d, 64'h0000_FFFF_FFFF_FFFB);
        wr_step(6'h31, 64'd0, "R10");
        read_reg(6'h11, d); chk("R10 arm zero clamps", d, 64'h0000_FFFF_8000_0001);
        wr_step(6'h31, 64'h8000_0000, "R10");
        read_reg(6'h11, d); chk("R10 arm large clamps", d, 64'h0000_FFFF_8000_0001);
        wr_step(6'h31, 64'hFFFF_FFFF_FFFF_FFFD, "R10");
        read_reg(6'h11, d); chk("R10 arm negative clamps", d, 64'h0000_FFFF_8000_0001);
        wr_step(6'h31, 64'h7FFF_FFFF, "R10");
        read_reg(6'h11, d); chk("R10 arm max kept", d, 64'h0000_FFFF_8000_0001);
        read_reg(6'h31, d); chk("R10 arm reads zero", d, 64'h0);

        // R3 R5 R7 R9: counter 0 on code 2, user only, interrupt on
        wr_step(6'h00, sel_img(8'd2, 8'd0, 8'd0, 1, 0, 1, 1), "R3");
        wr_step(6'h20, 64'h1, "R6");
        wr_step(6'h30, 64'd3, "R10");
        step(0, 6'h0, 64'h0, 4'b0011, 32'h0000_0202, 32'h0, 1, "R3 two lanes");
        read_reg(6'h10, d); chk("R3 sum of lanes", d, 64'h0000_FFFF_FFFF_FFFF);
        step(0, 6'h0, 64'h0, 4'b0001, 32'h0000_0002, 32'h0, 1, "R7 wrap");
        read_reg(6'h10, d); chk("R7 wrapped to zero", d, 64'h0);
        chk("R9 irq on overflow", 64'(irq), 64'h1);
        step(0, 6'h0, 64'h0, 4'b1100, 32'h0202_0000, 32'h0, 1, "R7 keeps counting");
        step(0, 6'h0, 64'h0, 4'b1111, 32'h0202_0202, 32'h0, 0, "R5 kernel blocked");
        read_reg(6'h10, d); chk("R5 privilege filter", d, 64'd2);
        wr_step(6'h22, 64'h2, "R8 other bit");
        read_reg(6'h21, d); chk("R8 zero bits kept", d, 64'h1);
        wr_step(6'h22, 64'h1, "R8 clear");
        chk("R9 irq drops", 64'(irq), 64'h0);

        // R3 unit mask, R4 threshold
        wr_step(6'h00, sel_img(8'd2, 8'h0C, 8'd0, 1, 1, 1, 1), "R3 mask");
        step(0, 6'h0, 64'h0, 4'b0111, 32'h0002_0202, 32'h0004_0801, 1, "R3 unit mask");
        read_reg(6'h10, d); chk("R3 unit mask filters", d, 64'd4);
        wr_step(6'h00, sel_img(8'd2, 8'h00, 8'd2, 1, 1, 1, 1), "R4");
        step(0, 6'h0, 64'h0, 4'b0001, 32'h0000_0002, 32'h0, 1, "R4 below threshold");
        step(0, 6'h0, 64'h0, 4'b0111, 32'h0002_0202, 32'h0, 1, "R4 at threshold");
        read_reg(6'h10, d); chk("R4 threshold adds one", d, 64'd5);

        // R6: freeze and resume
        wr_step(6'h20, 64'h0, "R6 freeze");
        step(0, 6'h0, 64'h0, 4'b1111, 32'h0202_0202, 32'h0, 1, "R6 frozen");
        read_reg(6'h10, d); chk("R6 frozen count", d, 64'd5);
        wr_step(6'h20, 64'h1, "R6 resume");
        step(0, 6'h0, 64'h0, 4'b1111, 32'h0202_0202, 32'h0, 1, "R6 resumed");
        read_reg(6'h10, d); chk("R6 resumed count", d, 64'd6);

        // R11: write beats count; R8: overflow beats clear
        step(1, 6'h10, 64'd100, 4'b1111, 32'h0202_0202, 32'h0, 1, "R11");
        read_reg(6'h10, d); chk("R11 write wins", d, 64'd100);
        wr_step(6'h00, sel_img(8'd2, 8'h00, 8'd0, 1, 1, 1, 1), "R8");
        wr_step(6'h30, 64'd1, "R8");
        step(0, 6'h0, 64'h0, 4'b0001, 32'h0000_0002, 32'h0, 1, "R8 first wrap");
        wr_step(6'h30, 64'd1, "R8");
        step(1, 6'h22, 64'h1, 4'b0001, 32'h0000_0002, 32'h0, 1, "R8 overflow beats clear");
        read_reg(6'h21, d); chk("R8 status kept", d, 64'h1);
        wr_step(6'h22, 64'hF, "R8");

        // Random traffic: R3 R4 R5 R7 R8 R11 together
        for (int c = 0; c < NC; c++) begin
            logic [7:0] um [4] = '{8'h00, 8'h01, 8'h03, 8'hF0};
            wr_step(6'h00 + 6'(c), sel_img(8'($urandom % 4), um[$urandom % 4],
                    8'($urandom % 4), 1'($urandom), 1'($urandom), 1'($urandom),
                    ($urandom % 4) != 0), "R3 R4 config");
            wr_step(6'h30 + 6'(c), 64'(1 + $urandom % 40), "R10 arm");
        end
        wr_step(6'h20, 64'hF, "R6");
        for (int n = 0; n < 1500; n++) begin
            int unsigned op = $urandom % 100;
            int unsigned c  = $urandom % NC;
            logic [31:0] cd;
            for (int l = 0; l < 4; l++) cd[l*8 +: 8] = 8'($urandom % 4);
            if (op < 8)
                step(1, 6'h30 + 6'(c), 64'(1 + $urandom % 40), 4'($urandom), cd, $urandom,
                     1'($urandom), "R11 R10 rand arm");
            else if (op < 11)
                step(1, 6'h22, 64'($urandom % 16), 4'($urandom), cd, $urandom,
                     1'($urandom), "R8 rand clear");
            else if (op < 14)
                step(1, 6'h20, 64'($urandom % 16), 4'($urandom), cd, $urandom,
                     1'($urandom), "R6 rand global");
            else if (op < 16)
                step(1, 6'h10 + 6'(c), {16'h0, 16'hFFFF, 32'hFFFF_FFF0 | 32'($urandom % 16)},
                     4'($urandom), cd, $urandom, 1'($urandom), "R11 rand write");
            else
                step(0, 6'h0, 64'h0, 4'($urandom), cd, $urandom, 1'($urandom),
                     "R3 R4 R5 R7 rand count");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", ntest, nfail);
        $finish;
    end
endmodule